// File: doc/BRIEF.md
# Dual-Bank Post-Modify Address Generator

This block produces two memory addresses in every instruction cycle: one for the data-memory space and one for the program-memory space. Each space has its own bank of four index registers and four modify registers. The data bank holds index registers 0 to 3 and modify registers 0 to 3. The program bank holds index registers 4 to 7 and modify registers 4 to 7. Each of the eight index registers also has its own length register.

The block drives the selected index value straight to the address output. When that space's fetch enable is high at a clock edge, the index register is written back with its value stepped by the selected signed modify value. A length of zero gives plain linear stepping. A nonzero length keeps the index inside a circular buffer of that length.

A host loads every index, modify and length register through one write port. The memories and the instruction decoder sit outside the block.

Top module: `dual_bank_agu`

## Requirements
- R1: While reset is asserted, all index, modify and length registers are cleared, so both address outputs read 0.
- R2: `dm_addr` equals the current value of index register `dm_isel` (0 to 3). This is the value before any update made at the coming edge.
- R3: `pm_addr` equals the current value of index register 4 + `pm_isel`. This is the value before any update made at the coming edge.
- R4: With `dm_en` high at an edge and the selected length at zero, index register `dm_isel` becomes its value plus modify register `dm_msel` (0 to 3). The modify value is 14-bit two's complement and the sum wraps modulo 2^14.
- R5: With `pm_en` high at an edge and the selected length at zero, index register 4 + `pm_isel` becomes its value plus modify register 4 + `pm_msel`. The arithmetic is the same as in R4.
- R6: A data-space step and a program-space step made at the same edge both take effect independently.
- R7: With a nonzero length L, the buffer base is the index with its low k bits cleared, where 2^k is the smallest power of two not below L. After adding the modify value, the result is corrected by −L or +L so that it lies in [base, base+L−1]. The index must start inside the window and |M| must not exceed L.
- R8: When `wr_en` is high at an edge, `wr_data` is loaded into register `wr_sel` (0 to 7) of the class given by `wr_kind`: 0 selects an index register, 1 a modify register and 2 a length register.
- R9: A host write to an index register at the same edge as that register's post-modify wins over the update.
- R10: `wr_kind` = 3 changes no register. An index register that is neither selected by an enabled fetch nor written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host register write strobe |
| wr_kind | input | 2 | Register class: 0 index, 1 modify, 2 length, 3 none |
| wr_sel | input | 3 | Register number 0 to 7 |
| wr_data | input | 14 | Value to load |
| dm_en | input | 1 | Post-modify the data-space index at this edge |
| dm_isel | input | 2 | Data-space index register select |
| dm_msel | input | 2 | Data-space modify register select |
| dm_addr | output | 14 | Data-memory address |
| pm_en | input | 1 | Post-modify the program-space index at this edge |
| pm_isel | input | 2 | Program-space index select (register 4 + value) |
| pm_msel | input | 2 | Program-space modify select (register 4 + value) |
| pm_addr | output | 14 | Program-memory address |

## Verification
The checker assumes that the host never drives `wr_kind` and `wr_sel` to an unknown value while `wr_en` is high. It also assumes reset is held low for at least one full clock edge before it is released. The circular properties of R7 rely on the caller keeping each index inside its window and keeping |M| no larger than L. The bench therefore loads every circular index with a value inside its window, and uses modify magnitudes below the length. Out-of-window starts are never generated.

// File: rtl/dual_bank_agu.sv
module dual_bank_agu #(
  parameter int IW = 14,
  parameter int NB = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_kind,
  input  logic [$clog2(2*NB)-1:0] wr_sel,
  input  logic [IW-1:0]          wr_data,
  input  logic                   dm_en,
  input  logic [$clog2(NB)-1:0]  dm_isel,
  input  logic [$clog2(NB)-1:0]  dm_msel,
  output logic [IW-1:0]          dm_addr,
  input  logic                   pm_en,
  input  logic [$clog2(NB)-1:0]  pm_isel,
  input  logic [$clog2(NB)-1:0]  pm_msel,
  output logic [IW-1:0]          pm_addr
);
  localparam int NR = 2 * NB;
  localparam int RW = $clog2(NR);
  localparam logic [1:0] K_IDX = 2'd0;
  localparam logic [1:0] K_MOD = 2'd1;
  localparam logic [1:0] K_LEN = 2'd2;

  logic [IW-1:0] idx [NR];
  logic [IW-1:0] mod [NR];
  logic [IW-1:0] len [NR];

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i,
                                         input logic [IW-1:0] m,
                                         input logic [IW-1:0] l);
    logic [IW-1:0] lm, mask, base;
    logic signed [IW+1:0] s, lo, hi, ls;
    lm   = l - 1'b1;
    mask = '0;
    for (int b = 0; b < IW; b++)
      if (lm[b]) mask = {IW{1'b1}} >> (IW - 1 - b);
    base = i & ~mask;
    s  = $signed({2'b00, i}) + $signed({{2{m[IW-1]}}, m});
    lo = $signed({2'b00, base});
    ls = $signed({2'b00, l});
    hi = lo + ls;
    if (l != '0) begin
      if (s >= hi)      s = s - ls;
      else if (s < lo)  s = s + ls;
    end
    return s[IW-1:0];
  endfunction

  wire [RW-1:0] dm_r  = RW'(dm_isel);
  wire [RW-1:0] dm_mr = RW'(dm_msel);
  wire [RW-1:0] pm_r  = RW'(NB) + RW'(pm_isel);
  wire [RW-1:0] pm_mr = RW'(NB) + RW'(pm_msel);

  assign dm_addr = idx[dm_r];
  assign pm_addr = idx[pm_r];

  wire [IW-1:0] dm_next = step(idx[dm_r], mod[dm_mr], len[dm_r]);
  wire [IW-1:0] pm_next = step(idx[pm_r], mod[pm_mr], len[pm_r]);

  for (genvar r = 0; r < NR; r++) begin : g_reg
    wire hit_w  = wr_en && (wr_sel == RW'(r));
    wire hit_dm = dm_en && (dm_r == RW'(r));
    wire hit_pm = pm_en && (pm_r == RW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx[r] <= '0;
        mod[r] <= '0;
        len[r] <= '0;
      end else begin
        if (hit_w && wr_kind == K_IDX) idx[r] <= wr_data;
        else if (hit_dm)               idx[r] <= dm_next;
        else if (hit_pm)               idx[r] <= pm_next;
        if (hit_w && wr_kind == K_MOD) mod[r] <= wr_data;
        if (hit_w && wr_kind == K_LEN) len[r] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/dual_bank_agu_chk.sv
module dual_bank_agu_chk #(
  parameter int IW = 14,
  parameter int NB = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [1:0]              wr_kind,
  input logic [$clog2(2*NB)-1:0] wr_sel,
  input logic [IW-1:0]           wr_data,
  input logic                    dm_en,
  input logic [$clog2(NB)-1:0]   dm_isel,
  input logic [$clog2(NB)-1:0]   dm_msel,
  input logic [IW-1:0]           dm_addr,
  input logic                    pm_en,
  input logic [$clog2(NB)-1:0]   pm_isel,
  input logic [$clog2(NB)-1:0]   pm_msel,
  input logic [IW-1:0]           pm_addr,
  input logic [IW-1:0]           idx [2*NB],
  input logic [IW-1:0]           mod [2*NB],
  input logic [IW-1:0]           len [2*NB]
);
  localparam int NR = 2 * NB;
  localparam int RW = $clog2(NR);

  wire [RW-1:0] dr  = RW'(dm_isel);
  wire [RW-1:0] dmr = RW'(dm_msel);
  wire [RW-1:0] pr  = RW'(NB) + RW'(pm_isel);
  wire [RW-1:0] pmr = RW'(NB) + RW'(pm_msel);
  wire wr_idx = wr_en && wr_kind == 2'd0;

  logic [NR*IW-1:0] idx_flat;
  always_comb
    for (int r = 0; r < NR; r++) idx_flat[r*IW +: IW] = idx[r];

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (dm_addr == '0 && pm_addr == '0));

  p_dm_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_en && len[dr] == '0 && !(wr_idx && wr_sel == dr))
    |=> idx[$past(dr)] == $past(IW'(dm_addr + mod[dmr])));

  p_pm_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_en && len[pr] == '0 && !(wr_idx && wr_sel == pr))
    |=> idx[$past(pr)] == $past(IW'(pm_addr + mod[pmr])));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> idx[$past(wr_sel)] == $past(wr_data));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !dm_en && !pm_en) |=> idx_flat == $past(idx_flat));
endmodule

bind dual_bank_agu dual_bank_agu_chk #(.IW(IW), .NB(NB)) u_chk (.*);

// File: tb/dual_bank_agu_bench.sv
`timescale 1ns/1ps
module dual_bank_agu_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_kind = 0;
  logic [2:0] wr_sel = 0;
  logic [13:0] wr_data = 0;
  logic dm_en = 0, pm_en = 0;
  logic [1:0] dm_isel = 0, dm_msel = 0, pm_isel = 0, pm_msel = 0;
  logic [13:0] dm_addr, pm_addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dual_bank_agu u_dual_bank_agu (.*);

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] s, input logic [13:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = k; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input bit pm, input logic [1:0] is, input logic [1:0] ms,
                     input int n, input logic [5*14-1:0] exp, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pm) begin pm_en = 1; pm_isel = is; pm_msel = ms; end
      else    begin dm_en = 1; dm_isel = is; dm_msel = ms; end
      #1 check(req, pm ? pm_addr : dm_addr, exp[k*14 +: 14]);
    end
    @(negedge clk);
    dm_en = 0; pm_en = 0;
    #1 check(req, pm ? pm_addr : dm_addr, exp[n*14 +: 14]);
  endtask

  task automatic t_reset;
    #1 check("R1 dm", dm_addr, 14'd0);
    check("R1 pm", pm_addr, 14'd0);
  endtask

  task automatic t_load;
    wr(2'd0, 3'd2, 14'd100);
    dm_isel = 2; #1 check("R8/R2 dm load", dm_addr, 14'd100);
    wr(2'd0, 3'd6, 14'h200);
    pm_isel = 2; #1 check("R8/R3 pm load", pm_addr, 14'h200);
  endtask

  task automatic t_linear;
    wr(2'd1, 3'd1, 14'd5);
    run(0, 2, 1, 3, {14'd0, 14'd115, 14'd110, 14'd105, 14'd100}, "R4 dm step");
    wr(2'd0, 3'd0, 14'h3FFE);
    wr(2'd1, 3'd0, 14'd3);
    run(0, 0, 0, 1, {14'd0, 14'd0, 14'd0, 14'h0001, 14'h3FFE}, "R4 wrap 2^14");
    wr(2'd1, 3'd5, 14'h3FFD);
    run(1, 2, 1, 3, {14'd0, 14'h1F7, 14'h1FA, 14'h1FD, 14'h200}, "R5 pm negative");
  endtask

  task automatic t_both;
    wr(2'd0, 3'd1, 14'd10);
    wr(2'd1, 3'd2, 14'd7);
    wr(2'd0, 3'd5, 14'd50);
    wr(2'd1, 3'd4, 14'd2);
    @(negedge clk);
    dm_isel = 1; dm_msel = 2; pm_isel = 1; pm_msel = 0;
    #1 check("R6 dm c0", dm_addr, 14'd10); check("R6 pm c0", pm_addr, 14'd50);
    for (int k = 1; k <= 2; k++) begin
      dm_en = 1; pm_en = 1;
      @(negedge clk);
      #1 check("R6 dm", dm_addr, 14'(10 + 7*k));
      check("R6 pm", pm_addr, 14'(50 + 2*k));
    end
    dm_en = 0; pm_en = 0;
  endtask

  task automatic t_circ;
    wr(2'd2, 3'd3, 14'd10);
    wr(2'd0, 3'd3, 14'd71);
    wr(2'd1, 3'd2, 14'd4);
    run(0, 3, 2, 4, {14'd67, 14'd73, 14'd69, 14'd65, 14'd71}, "R7 circ up");
    wr(2'd2, 3'd7, 14'd10);
    wr(2'd0, 3'd7, 14'd129);
    wr(2'd1, 3'd6, 14'h3FFC);
    run(1, 3, 2, 3, {14'd0, 14'd137, 14'd131, 14'd135, 14'd129}, "R7 circ down");
  endtask

  task automatic t_priority;
    @(negedge clk);
    dm_isel = 2; dm_msel = 1; dm_en = 1;
    wr_en = 1; wr_kind = 0; wr_sel = 2; wr_data = 14'h123;
    @(negedge clk);
    dm_en = 0; wr_en = 0;
    #1 check("R9 write wins", dm_addr, 14'h123);
  endtask

  task automatic t_ignore;
    wr(2'd3, 3'd2, 14'h0);
    dm_isel = 2; #1 check("R10 kind3 idx", dm_addr, 14'h123);
    wr(2'd3, 3'd1, 14'h0);
    run(0, 2, 1, 1, {14'd0, 14'd0, 14'd0, 14'h128, 14'h123}, "R10 kind3 mod");
    dm_isel = 0; #1 check("R10 untouched I0", dm_addr, 14'h0001);
    pm_isel = 2; #1 check("R10 untouched I6", pm_addr, 14'h1F7);
  endtask

  initial begin
    #5 t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_load();
    t_linear();
    t_both();
    t_circ();
    t_priority();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule